// File: doc/BRIEF.md
# Boundary-Splitting Scatter-Gather Descriptor Generator

This block turns a stream of scatter-gather segments into a descriptor table for a bus-master transfer engine. Each segment is a start address and a byte length. The block splits a segment wherever it would cross a 64 KiB address boundary. It emits one 16-byte entry for each resulting chunk, as four 32-bit words in big-endian byte order. The final entry of the list carries an end-of-list flag.

The block does not know whether an entry is the last one until the next chunk or the end of the list is known. For that reason it holds back the length word of each entry until that is settled. The table has a fixed capacity. If a list needs more entries than that, the block reports overflow with a count of zero, so the caller can abandon the table and use programmed I/O instead. At the end of every list a one-cycle done pulse carries the final entry count. The table storage is outside the block.

Top module: `seg_desc_gen`

## Requirements
- R1: A chunk starting at address A with R bytes remaining has length min(R, 0x10000 - (A mod 0x10000)). The next chunk starts at A plus that length, with R reduced by the same amount, until R is zero. Each chunk produces exactly one entry.
- R2: Each entry is four words on out_data, in this order: zero, chunk address, zero, chunk length. Every word is byte-swapped: native bits [7:0] appear on out_data[31:24], [15:8] on [23:16], [23:16] on [15:8] and [31:24] on [7:0].
- R3: The end-of-list flag is native bit 31 of the length word, which appears on out_data[7]. It is set in the length word of the final entry of a list and in no other word.
- R4: A list may hold at most MAX_ENTRIES entries. A list of exactly MAX_ENTRIES entries completes normally. A list that needs one more entry ends with overflow high and a count of 0 during the done pulse.
- R5: After an overflow, the block accepts and discards input segments up to and including the segment flagged last. The next list is then processed normally.
- R6: A list whose first segment has zero length produces no words and finishes with a count of 0 and overflow low.
- R7: Processing stops at the first zero-length segment. Later segments up to the last-flagged one are accepted without effect, and the entries already produced end with the end-of-list flag on the final one.
- R8: done is high for exactly one cycle per list, and done_count carries the number of entries emitted.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.
- R10: During reset, in_ready is high, out_valid is low and done is low.
- R11: in_ready is never high while out_valid is high, so one segment is processed at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Segment offered |
| in_ready | output | 1 | Segment accepted when high with in_valid |
| in_addr | input | ADDR_W | Segment start address |
| in_len | input | LEN_W | Segment length in bytes |
| in_last | input | 1 | Final segment of the list |
| out_valid | output | 1 | Descriptor word offered |
| out_ready | input | 1 | Descriptor word taken when high with out_valid |
| out_data | output | 32 | Descriptor word, byte-swapped |
| done | output | 1 | One-cycle end-of-list pulse |
| done_count | output | CNT_W | Entries in the finished list, 0 on overflow |
| overflow | output | 1 | High with done when the table would overflow |

## Verification
Results arrive at different points after the stimulus that causes them. The first word of a list becomes valid two cycles after its segment is accepted. Every later word becomes valid in the cycle after the previous word's handshake. The held-back length word of the final entry appears only once the end of the list is known, and done rises one cycle after that word is taken. The bench drives and samples only on falling edges, so it sees each handshake through the value present just before the next rising edge. It records each accepted word when that handshake occurs. Instead of assuming a fixed delay, it waits for the done pulse and then compares the whole list, the count and the overflow flag with an arithmetic model.

// File: rtl/segdesc_pkg.sv
package segdesc_pkg;
    localparam int WORD_W  = 32;
    localparam int EOL_BIT = 31;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EMIT,
        ST_DRAIN,
        ST_TAIL,
        ST_DONE
    } state_e;

    typedef enum logic [1:0] {
        WK_ZERO,
        WK_ADDR,
        WK_LEN
    } wkind_e;

    // reverse byte order of a native word for the big-endian table
    function automatic logic [WORD_W-1:0] to_big(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < WORD_W / 8; b++) begin
            r[8*b +: 8] = v[8*(WORD_W/8 - 1 - b) +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/seg_chunk_calc.sv
module seg_chunk_calc #(
    parameter int LEN_W   = 24,
    parameter int BOUND_W = 16
) (
    input  logic [BOUND_W-1:0] addr_lo_i,
    input  logic [LEN_W-1:0]   rem_i,
    output logic [LEN_W-1:0]   chunk_o
);
    localparam int SPAN_W = BOUND_W + 1;

    logic [SPAN_W-1:0] span;
    logic [LEN_W-1:0]  span_l;

    // bytes left before the next aligned boundary
    assign span    = SPAN_W'(1 << BOUND_W) - SPAN_W'(addr_lo_i);
    assign span_l  = LEN_W'(span);
    assign chunk_o = (rem_i < span_l) ? rem_i : span_l;
endmodule

// File: rtl/seg_word_fmt.sv
module seg_word_fmt
    import segdesc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24
) (
    input  wkind_e              kind_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic                eol_i,
    output logic [WORD_W-1:0]   data_o
);
    logic [WORD_W-1:0] native;

    always_comb begin
        native = '0;
        unique case (kind_i)
            WK_ADDR: native = WORD_W'(addr_i);
            WK_LEN: begin
                native          = WORD_W'(len_i);
                native[EOL_BIT] = native[EOL_BIT] | eol_i;
            end
            default: native = '0;
        endcase
    end

    assign data_o = to_big(native);
endmodule

// File: rtl/seg_desc_gen.sv
module seg_desc_gen
    import segdesc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 24,
    parameter int BOUND_W     = 16,
    parameter int MAX_ENTRIES = 64,
    localparam int CNT_W      = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              done,
    output logic [CNT_W-1:0]  done_count,
    output logic              overflow
);
    typedef struct packed {
        state_e             st;
        logic [1:0]         widx;
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   rem;
        logic               last;
        logic [LEN_W-1:0]   pend;
        logic               pend_v;
        logic [CNT_W-1:0]   cnt;
        logic               ovf;
    } regs_t;

    regs_t q, d;

    logic [LEN_W-1:0] chunk;
    wkind_e           kind;
    logic             eol;
    logic             at_limit;

    seg_chunk_calc #(
        .LEN_W  (LEN_W),
        .BOUND_W(BOUND_W)
    ) u_chunk (
        .addr_lo_i(q.addr[BOUND_W-1:0]),
        .rem_i    (q.rem),
        .chunk_o  (chunk)
    );

    seg_word_fmt #(
        .ADDR_W(ADDR_W),
        .LEN_W (LEN_W)
    ) u_fmt (
        .kind_i(kind),
        .addr_i(q.addr),
        .len_i (q.pend),
        .eol_i (eol),
        .data_o(out_data)
    );

    assign at_limit = (q.cnt == CNT_W'(MAX_ENTRIES));

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        kind      = WK_ZERO;
        eol       = 1'b0;
        unique case (q.st)
            ST_FETCH: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (in_len == '0) begin
                        d.st = in_last ? ST_TAIL : ST_DRAIN;
                    end else begin
                        d.addr = in_addr;
                        d.rem  = in_len;
                        d.last = in_last;
                        d.widx = 2'd0;
                        d.st   = ST_EMIT;
                    end
                end
            end
            ST_EMIT: begin
                unique case (q.widx)
                    2'd0: begin
                        // a new entry is needed: check room, then release held length
                        if (at_limit) begin
                            d.ovf    = 1'b1;
                            d.pend_v = 1'b0;
                            d.st     = q.last ? ST_TAIL : ST_DRAIN;
                        end else if (q.pend_v) begin
                            out_valid = 1'b1;
                            kind      = WK_LEN;
                            if (out_ready) begin
                                d.pend_v = 1'b0;
                                d.widx   = 2'd1;
                            end
                        end else begin
                            d.widx = 2'd1;
                        end
                    end
                    2'd1: begin
                        out_valid = 1'b1;
                        if (out_ready) d.widx = 2'd2;
                    end
                    2'd2: begin
                        out_valid = 1'b1;
                        kind      = WK_ADDR;
                        if (out_ready) d.widx = 2'd3;
                    end
                    default: begin
                        out_valid = 1'b1;
                        if (out_ready) begin
                            d.pend   = chunk;
                            d.pend_v = 1'b1;
                            d.cnt    = q.cnt + CNT_W'(1);
                            d.addr   = q.addr + ADDR_W'(chunk);
                            d.rem    = q.rem - chunk;
                            d.widx   = 2'd0;
                            if (q.rem == chunk) d.st = q.last ? ST_TAIL : ST_FETCH;
                        end
                    end
                endcase
            end
            ST_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && in_last) d.st = ST_TAIL;
            end
            ST_TAIL: begin
                if (q.pend_v) begin
                    out_valid = 1'b1;
                    kind      = WK_LEN;
                    eol       = 1'b1;
                    if (out_ready) begin
                        d.pend_v = 1'b0;
                        d.st     = ST_DONE;
                    end
                end else begin
                    d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                d.st     = ST_FETCH;
                d.cnt    = '0;
                d.ovf    = 1'b0;
                d.pend_v = 1'b0;
            end
            default: d.st = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done       = (q.st == ST_DONE);
    assign overflow   = done && q.ovf;
    assign done_count = q.ovf ? '0 : q.cnt;
endmodule

// File: rtl/seg_desc_gen_chk.sv
module seg_desc_gen_chk #(
    parameter int MAX_ENTRIES = 64,
    parameter int CNT_W       = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_data,
    input logic             done,
    input logic [CNT_W-1:0] done_count,
    input logic             overflow
);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("R9 word changed while stalled");

    p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("R8 done longer than one cycle");

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (done && done_count == '0))
        else $error("R4 overflow without done or with nonzero count");

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count <= CNT_W'(MAX_ENTRIES)))
        else $error("R4 count above capacity");

    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready)
        else $error("R11 input open while emitting");
endmodule

bind seg_desc_gen seg_desc_gen_chk #(
    .MAX_ENTRIES(MAX_ENTRIES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .done      (done),
    .done_count(done_count),
    .overflow  (overflow)
);

// File: tb/tb_seg_desc_gen.sv
module tb_seg_desc_gen;
    localparam int MAXE = 4;
    localparam int LW   = 20;
    localparam int CW   = $clog2(MAXE + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   in_addr = '0;
    logic [LW-1:0] in_len = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [31:0]   out_data;
    logic          done;
    logic [CW-1:0] done_count;
    logic          overflow;

    always #5 clk = ~clk;

    seg_desc_gen #(.LEN_W(LW), .MAX_ENTRIES(MAXE)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
        .in_len(in_len), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .done_count(done_count), .overflow(overflow)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [31:0]   seg_a [8];
    logic [LW-1:0] seg_l [8];
    logic          seg_f [8];
    int            nseg;

    logic [31:0] exp_w [64];
    int          exp_n, exp_cnt;
    bit          exp_ovf;
    logic [31:0] got_w [64];
    int          got_n = 0;
    bit          done_seen = 0;
    int          got_cnt;
    bit          got_ovf;
    bit          slow = 0;
    bit          stall_prev = 0;
    logic [31:0] stall_data;
    bit          done_prev = 0;

    function automatic logic [31:0] be(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // falling-edge monitor: set ready, then observe handshakes and pulses
    always @(negedge clk) begin
        cyc++;
        out_ready = slow ? (cyc % 3 != 0) : 1'b1;
        if (rst_n) begin
            if (stall_prev)
                chk(out_valid && out_data == stall_data, "R9", "stalled word",
                    out_data, stall_data);
            stall_prev = out_valid && !out_ready;
            stall_data = out_data;
            if (out_valid) chk(!in_ready, "R11", "in_ready while emitting", in_ready, 0);
            if (out_valid && out_ready) begin
                if (got_n < 64) got_w[got_n] = out_data;
                got_n++;
            end
            if (done_prev) chk(!done, "R8", "done second cycle", done, 0);
            if (done) begin
                done_seen = 1;
                got_cnt   = int'(done_count);
                got_ovf   = overflow;
            end
            done_prev = done;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog: actual=no_done expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic add(input logic [31:0] a, input logic [LW-1:0] l, input logic f);
        seg_a[nseg] = a;
        seg_l[nseg] = l;
        seg_f[nseg] = f;
        nseg++;
    endtask

    task automatic build_expected();
        longint a, l, b, lastb;
        int     cnt;
        exp_n   = 0;
        cnt     = 0;
        exp_ovf = 0;
        lastb   = 0;
        for (int i = 0; i < nseg; i++) begin
            if (seg_l[i] == 0 || exp_ovf) break;
            a = seg_a[i];
            l = seg_l[i];
            while (l > 0 && !exp_ovf) begin
                if (cnt == MAXE) begin
                    exp_ovf = 1;
                end else begin
                    b = 65536 - (a % 65536);
                    if (b > l) b = l;
                    exp_w[exp_n]   = 32'h0;
                    exp_w[exp_n+1] = be(32'(a));
                    exp_w[exp_n+2] = 32'h0;
                    exp_w[exp_n+3] = be(32'(b));
                    exp_n += 4;
                    cnt++;
                    lastb = b;
                    a += b;
                    l -= b;
                end
            end
        end
        if (exp_ovf) begin
            exp_n   = exp_n - 1;
            exp_cnt = 0;
        end else begin
            exp_cnt = cnt;
            if (cnt > 0) exp_w[exp_n-1] = be(32'(lastb) | 32'h8000_0000);
        end
    endtask

    task automatic send(input int i);
        in_addr  = seg_a[i];
        in_len   = seg_l[i];
        in_last  = seg_f[i];
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_list(input string req);
        build_expected();
        got_n     = 0;
        done_seen = 0;
        for (int i = 0; i < nseg; i++) send(i);
        while (!done_seen) @(negedge clk);
        chk(got_ovf == exp_ovf, req, "overflow", got_ovf, exp_ovf);
        chk(got_cnt == exp_cnt, req, "entry count", got_cnt, exp_cnt);
        chk(got_n == exp_n, req, "word count", got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++)
            chk(got_w[k] == exp_w[k], (k == exp_n - 1 && !exp_ovf) ? "R3" : "R2",
                $sformatf("word %0d", k), got_w[k], exp_w[k]);
        @(negedge clk);
        nseg = 0;
    endtask

    initial begin
        int offs [4];
        int lens [6];
        offs = '{0, 1, 32'h7FFF, 32'hFFFF};
        lens = '{1, 32'hFFFF, 32'h10000, 32'h10001, 32'h2FFFF, 32'h40000};
        nseg = 0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
        chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
        chk(done == 1'b0, "R10", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 chunk inside one window, then one crossing a boundary
        add(32'h0000_1000, 20'h200, 1); run_list("R1");
        slow = 1;
        add(32'h0001_FF00, 20'h300, 1); run_list("R1");
        // R3 flag lands only on the last entry of a multi-segment list
        add(32'h0000_3000, 20'h100, 0); add(32'h0005_FFF0, 20'h20, 0);
        add(32'h0007_0000, 20'h10, 1); run_list("R3");
        slow = 0;
        // R4 exactly at capacity, then one entry beyond it
        add(32'h0008_0000, 20'h40000, 1); run_list("R4");
        slow = 1;
        add(32'h0000_0001, 20'h20000, 0); add(32'h0009_0000, 20'h20000, 1); run_list("R4");
        // R5 overflow with trailing segments, then a normal list
        add(32'h0000_FFFF, 20'h40000, 0); add(32'h0000_0100, 20'h10, 0);
        add(32'h0000_0200, 20'h10, 1); run_list("R5");
        add(32'h0000_4000, 20'h40, 1); run_list("R5");
        slow = 0;
        // R6 empty list forms
        add(32'h0000_5000, 20'h0, 1); run_list("R6");
        add(32'h0000_5000, 20'h0, 0); add(32'h0000_6000, 20'h10, 1); run_list("R6");
        // R7 stop at a zero-length segment in the middle
        add(32'h0000_1000, 20'h10, 0); add(32'h0000_2000, 20'h0, 0);
        add(32'h0000_3000, 20'h10, 1); run_list("R7");

        // R1 sweep of boundary offsets against lengths
        for (int oi = 0; oi < 4; oi++) begin
            for (int li = 0; li < 6; li++) begin
                slow = ((oi + li) % 2) == 1;
                add(32'h0012_0000 + 32'(offs[oi]), LW'(lens[li]), 1);
                run_list("R1");
            end
        end
        slow = 0;
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule